// File: doc/BRIEF.md
# Debug Mode Flow Controller

This block decides whether a small CPU core executes its program normally or sits in a debug state. A debugger writes commands and configuration through a simple write-strobe port. Breakpoint hits from the comparators also stop the core. Once stopped, the core gets its instructions from one of two places, chosen by a configuration bit. In direct mode a debugger-loaded instruction register supplies them, and the core is stalled while that register is empty. In monitor mode the core runs a monitor routine from program memory, starting at a fixed entry vector, and the instruction register plays no part.

A single-step command takes the core out of debug for exactly one program-memory instruction. The controller allows one fetch, waits for that instruction to retire, passes through a one-cycle return state and then stops again. The core pipeline is represented only by a fetch-request strobe and a retire strobe. The controller answers with a fetch-source select, a stall, the loaded instruction and status: the current state and a sticky record of the last entry cause.

Top module: `dbg_flow_ctrl`

## Requirements
- R1: While in RUN (state_o=0), a breakpoint hit or a halt command moves the controller to DEBUG (state_o=1) at the next clock edge. The halt command is bit 0 of a write to address 0.
- R2: cause_o records the reason for the most recent entry to DEBUG and holds it until the next entry. The codes are 1 for a breakpoint, 2 for a halt command and 3 for a completed step. A breakpoint takes precedence over a halt command in the same cycle. After reset cause_o is 0.
- R3: Direct mode is selected by configuration bit 0 = 0 at address 2. In DEBUG in direct mode, fetch_src_o is 1 and stall_o is high exactly while the instruction register is empty.
- R4: A write to address 1 loads dinst_o and sets dinst_full_o. In DEBUG in direct mode, a fetch_req_i with the register full hands the instruction to the core and clears the flag at that edge. A write in the same cycle as a hand-off leaves the flag set and holds the new value.
- R5: Monitor mode is selected by configuration bit 0 = 1. In DEBUG in monitor mode, fetch_src_o is 2 and stall_o is low whatever the instruction register holds. fetch_req_i does not clear dinst_full_o. mon_entry_o is high for the first DEBUG cycle only, and mon_vec_o carries the MON_VEC parameter.
- R6: The step command is bit 2 of a write to address 0 and is accepted only in DEBUG, where it moves to STEP_RUN (state_o=2). In STEP_RUN, fetch_src_o is 0. The first fetch_req_i is let through, after which stall_o stays high.
- R7: A retire_i in STEP_RUN moves to STEP_RETURN (state_o=3), which holds stall_o high for one cycle and then enters DEBUG with cause_o=3.
- R8: The resume command is bit 1 of a write to address 0; in DEBUG it returns to RUN. Resume in RUN, step in RUN, and a halt command in DEBUG have no effect on state_o or cause_o. A step and a resume in the same write select STEP_RUN.
- R9: After reset the controller is in RUN in direct mode with fetch_src_o=0, stall_o low, dinst_full_o low and cause_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address: 0 command, 1 instruction, 2 configuration |
| reg_wdata_i | input | DW | Register write data |
| bkpt_hit_i | input | 1 | Breakpoint hit from the comparators |
| fetch_req_i | input | 1 | Core fetch request |
| retire_i | input | 1 | Core retired one instruction |
| fetch_src_o | output | 2 | 0 program memory, 1 instruction register, 2 monitor |
| stall_o | output | 1 | Holds the core |
| dinst_o | output | IW | Debugger-loaded instruction |
| dinst_full_o | output | 1 | Instruction register holds an unused instruction |
| mon_vec_o | output | 32 | Monitor entry vector |
| mon_entry_o | output | 1 | First debug cycle in monitor mode |
| state_o | output | 2 | 0 RUN, 1 DEBUG, 2 STEP_RUN, 3 STEP_RETURN |
| cause_o | output | 2 | Last entry cause: 0 none, 1 breakpoint, 2 request, 3 step |

## Verification
The assertions assume that fetch_req_i and retire_i come from a core that obeys stall_o. They also assume that a halt, breakpoint or step is a single-cycle pulse. The stimulus meets these assumptions in three ways. It raises each strobe for exactly one cycle. It issues a fetch only when the core would be allowed to fetch. It retires the stepped instruction only after its fetch was taken. One deliberate exception is a fetch during a monitor-mode stop, which shows that the instruction register is left untouched.

// File: rtl/dbg_flow_pkg.sv
package dbg_flow_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_DEBUG    = 2'd1,
    ST_STEP_RUN = 2'd2,
    ST_STEP_RET = 2'd3
  } dbg_state_e;

  typedef enum logic [1:0] {
    SRC_PROG = 2'd0,
    SRC_DIR  = 2'd1,
    SRC_MON  = 2'd2
  } fetch_src_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_BKPT = 2'd1,
    CAUSE_REQ  = 2'd2,
    CAUSE_STEP = 2'd3
  } dbg_cause_e;

  localparam int unsigned ADDR_CMD  = 0;
  localparam int unsigned ADDR_INST = 1;
  localparam int unsigned ADDR_CFG  = 2;

  localparam int unsigned CMD_HALT   = 0;
  localparam int unsigned CMD_RESUME = 1;
  localparam int unsigned CMD_STEP   = 2;
endpackage

// File: rtl/dbg_inst_reg.sv
module dbg_inst_reg #(
  parameter int unsigned IW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [IW-1:0] inst_o
);
  logic          full_q;
  logic [IW-1:0] inst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      inst_q <= '0;
    end else begin
      if (wr_i) begin
        full_q <= 1'b1;  // a fresh write wins over a hand-off
        inst_q <= wdata_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign inst_o = inst_q;
endmodule

// File: rtl/dbg_step_fsm.sv
module dbg_step_fsm
  import dbg_flow_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       bkpt_i,
  input  logic       resume_i,
  input  logic       step_i,
  input  logic       fetch_i,
  input  logic       retire_i,
  output dbg_state_e state_o,
  output dbg_cause_e cause_o,
  output logic       step_fetched_o,
  output logic       entry_o
);
  dbg_state_e state_q, state_d;
  dbg_cause_e cause_q, cause_d;
  logic       fetched_q, fetched_d;
  logic       entry_q;

  always_comb begin
    state_d   = state_q;
    cause_d   = cause_q;
    fetched_d = fetched_q;
    unique case (state_q)
      ST_RUN: begin
        if (bkpt_i || halt_i) begin
          state_d = ST_DEBUG;
          cause_d = bkpt_i ? CAUSE_BKPT : CAUSE_REQ;
        end
      end
      ST_DEBUG: begin
        if (step_i) begin
          state_d   = ST_STEP_RUN;
          fetched_d = 1'b0;
        end else if (resume_i) begin
          state_d = ST_RUN;
        end
      end
      ST_STEP_RUN: begin
        if (fetch_i) fetched_d = 1'b1;
        if (retire_i) state_d = ST_STEP_RET;
      end
      ST_STEP_RET: begin
        state_d = ST_DEBUG;
        cause_d = CAUSE_STEP;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      cause_q   <= CAUSE_NONE;
      fetched_q <= 1'b0;
      entry_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      cause_q   <= cause_d;
      fetched_q <= fetched_d;
      entry_q   <= (state_d == ST_DEBUG) && (state_q != ST_DEBUG);
    end
  end

  assign state_o        = state_q;
  assign cause_o        = cause_q;
  assign step_fetched_o = fetched_q;
  assign entry_o        = entry_q;
endmodule

// File: rtl/dbg_flow_ctrl.sv
module dbg_flow_ctrl
  import dbg_flow_pkg::*;
#(
  parameter int unsigned AW      = 2,
  parameter int unsigned DW      = 32,
  parameter int unsigned IW      = 32,
  parameter logic [31:0] MON_VEC = 32'h0000_0400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          bkpt_hit_i,
  input  logic          fetch_req_i,
  input  logic          retire_i,
  output logic [1:0]    fetch_src_o,
  output logic          stall_o,
  output logic [IW-1:0] dinst_o,
  output logic          dinst_full_o,
  output logic [31:0]   mon_vec_o,
  output logic          mon_entry_o,
  output logic [1:0]    state_o,
  output logic [1:0]    cause_o
);
  localparam int unsigned CW = (IW < DW) ? IW : DW;

  logic       cmd_wr, inst_wr, cfg_wr;
  logic       halt_cmd, resume_cmd, step_cmd;
  logic       mon_mode_q;
  logic       take, step_fetched, entry;
  logic [IW-1:0] inst_wdata;
  dbg_state_e state;
  dbg_cause_e cause;
  fetch_src_e src;

  assign cmd_wr     = reg_we_i && (reg_addr_i == AW'(ADDR_CMD));
  assign inst_wr    = reg_we_i && (reg_addr_i == AW'(ADDR_INST));
  assign cfg_wr     = reg_we_i && (reg_addr_i == AW'(ADDR_CFG));
  assign halt_cmd   = cmd_wr && reg_wdata_i[CMD_HALT];
  assign resume_cmd = cmd_wr && reg_wdata_i[CMD_RESUME];
  assign step_cmd   = cmd_wr && reg_wdata_i[CMD_STEP];

  always_comb begin
    inst_wdata       = '0;
    inst_wdata[CW-1:0] = reg_wdata_i[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mon_mode_q <= 1'b0;
    else if (cfg_wr) mon_mode_q <= reg_wdata_i[0];
  end

  dbg_step_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .halt_i        (halt_cmd),
    .bkpt_i        (bkpt_hit_i),
    .resume_i      (resume_cmd),
    .step_i        (step_cmd),
    .fetch_i       (fetch_req_i && !stall_o),
    .retire_i      (retire_i),
    .state_o       (state),
    .cause_o       (cause),
    .step_fetched_o(step_fetched),
    .entry_o       (entry)
  );

  // direct-mode hand-off only
  assign take = fetch_req_i && (state == ST_DEBUG) && !mon_mode_q && dinst_full_o;

  dbg_inst_reg #(.IW(IW)) u_inst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (inst_wr),
    .wdata_i(inst_wdata),
    .take_i (take),
    .full_o (dinst_full_o),
    .inst_o (dinst_o)
  );

  always_comb begin
    src     = SRC_PROG;
    stall_o = 1'b0;
    unique case (state)
      ST_DEBUG: begin
        src     = mon_mode_q ? SRC_MON : SRC_DIR;
        stall_o = !mon_mode_q && !dinst_full_o;
      end
      ST_STEP_RUN: stall_o = step_fetched;
      ST_STEP_RET: begin
        src     = mon_mode_q ? SRC_MON : SRC_DIR;
        stall_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign fetch_src_o = src;
  assign mon_vec_o   = MON_VEC;
  assign mon_entry_o = entry && mon_mode_q;
  assign state_o     = state;
  assign cause_o     = cause;
endmodule

// File: rtl/dbg_flow_ctrl_chk.sv
module dbg_flow_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bkpt_hit_i,
  input logic       fetch_req_i,
  input logic       retire_i,
  input logic       halt_cmd,
  input logic       resume_cmd,
  input logic       step_cmd,
  input logic       inst_wr,
  input logic       mon_mode_q,
  input logic [1:0] state_o,
  input logic [1:0] cause_o,
  input logic [1:0] fetch_src_o,
  input logic       stall_o,
  input logic       dinst_full_o
);
  p_entry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && (bkpt_hit_i || halt_cmd)) |=> state_o == 2'd1);

  p_bkpt_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && bkpt_hit_i) |=> cause_o == 2'd1);

  p_dir_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && !mon_mode_q) |-> (fetch_src_o == 2'd1 && stall_o == !dinst_full_o));

  p_wr_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_wr |=> dinst_full_o);

  p_mon_nostall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && mon_mode_q) |-> (fetch_src_o == 2'd2 && !stall_o));

  p_step_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |-> fetch_src_o == 2'd0);

  p_step_ret_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 |=> (state_o == 2'd1 && cause_o == 2'd3));

  p_step_retire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && retire_i) |=> state_o == 2'd3);

  p_resume_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && !bkpt_hit_i && !halt_cmd && (resume_cmd || step_cmd)) |=> state_o == 2'd0);

  p_cause_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && !step_cmd && !fetch_req_i) |=> $stable(cause_o));
endmodule

bind dbg_flow_ctrl dbg_flow_ctrl_chk u_chk (.*);

// File: tb/dbg_flow_ctrl_test.sv
module dbg_flow_ctrl_test;
  localparam logic [31:0] VEC = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        bkpt = 1'b0, fetch = 1'b0, retire = 1'b0;
  logic [1:0]  src, state, cause;
  logic        stall, full, mentry;
  logic [31:0] dinst, mvec;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dbg_flow_ctrl #(.MON_VEC(VEC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .bkpt_hit_i(bkpt), .fetch_req_i(fetch),
    .retire_i(retire), .fetch_src_o(src), .stall_o(stall), .dinst_o(dinst),
    .dinst_full_o(full), .mon_vec_o(mvec), .mon_entry_o(mentry),
    .state_o(state), .cause_o(cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, returns at the following negedge
  task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d,
                     input logic b, input logic f, input logic r);
    @(negedge clk);
    we = w; addr = a; wdata = d; bkpt = b; fetch = f; retire = r;
    @(negedge clk);
    we = 1'b0; bkpt = 1'b0; fetch = 1'b0; retire = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 state", state, 0); chk("R9 src", src, 0); chk("R9 stall", stall, 0);
    chk("R9 cause", cause, 0); chk("R9 full", full, 0); chk("R9 mentry", mentry, 0);
  endtask

  task automatic t_ignored_in_run;
    cyc(1, 2'd0, 32'h2, 0, 0, 0);
    chk("R8 resume in run", state, 0);
    cyc(1, 2'd0, 32'h4, 0, 0, 0);
    chk("R6 step in run", state, 0);
    chk("R8 cause unchanged", cause, 0);
  endtask

  task automatic t_halt_direct;
    cyc(1, 2'd0, 32'h1, 0, 0, 0);
    chk("R1 halt entry", state, 1); chk("R2 cause req", cause, 2);
    chk("R3 src dir", src, 1); chk("R3 stall empty", stall, 1);
    cyc(1, 2'd1, 32'hA5, 0, 0, 0);
    chk("R4 full set", full, 1); chk("R4 data", dinst, 32'hA5); chk("R3 no stall", stall, 0);
    cyc(0, 2'd0, 0, 0, 1, 0);
    chk("R4 taken clears", full, 0); chk("R3 stall again", stall, 1);
    cyc(1, 2'd1, 32'hB0, 0, 0, 0);
    cyc(1, 2'd1, 32'hC3, 0, 1, 0);
    chk("R4 write+take full", full, 1); chk("R4 write+take data", dinst, 32'hC3);
    cyc(1, 2'd0, 32'h1, 0, 0, 0);
    chk("R8 halt in debug state", state, 1); chk("R8 halt in debug cause", cause, 2);
  endtask

  task automatic t_step;
    cyc(1, 2'd0, 32'h6, 0, 0, 0);  // step+resume: step wins
    chk("R6 step state", state, 2); chk("R6 src prog", src, 0); chk("R6 no stall", stall, 0);
    cyc(0, 2'd0, 0, 0, 1, 0);
    chk("R6 one fetch then stall", stall, 1); chk("R6 still step", state, 2);
    cyc(0, 2'd0, 0, 0, 0, 1);
    chk("R7 return state", state, 3); chk("R7 return stall", stall, 1);
    @(negedge clk);
    chk("R7 back in debug", state, 1); chk("R7 cause step", cause, 3);
  endtask

  task automatic t_resume_bkpt;
    cyc(1, 2'd0, 32'h2, 0, 0, 0);
    chk("R8 resume", state, 0); chk("R8 src prog", src, 0);
    cyc(1, 2'd0, 32'h1, 1, 0, 0);
    chk("R1 bkpt entry", state, 1); chk("R2 bkpt priority", cause, 1);
    cyc(1, 2'd0, 32'h2, 0, 0, 0);
    chk("R2 cause sticky in run", cause, 1);
  endtask

  task automatic t_monitor;
    cyc(1, 2'd2, 32'h1, 0, 0, 0);
    cyc(1, 2'd0, 32'h1, 0, 0, 0);
    chk("R5 src mon", src, 2); chk("R5 no stall", stall, 0);
    chk("R5 entry pulse", mentry, 1); chk("R5 vector", mvec, VEC);
    @(negedge clk);
    chk("R5 pulse ends", mentry, 0);
    cyc(1, 2'd1, 32'h77, 0, 0, 0);
    chk("R5 write ignored src", src, 2); chk("R5 write ignored stall", stall, 0);
    cyc(0, 2'd0, 0, 0, 1, 0);
    chk("R5 fetch keeps full", full, 1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_ignored_in_run;
    t_halt_direct;
    t_step;
    t_resume_bkpt;
    t_monitor;
    finish_run;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end
endmodule